// File: doc/BRIEF.md
# Serial Channel Modem Control Logic

This block looks after the modem handshake lines of one serial channel. Two active-low line inputs, clear-to-send and carrier-detect, are brought into the clock domain through a synchronizer. The synchronized inputs are then used in two ways. They are reported as status. When automatic enabling is selected, they also gate the transmitter enable and the receiver enable. A change of either input in either direction sets a sticky change flag. The flags, masked per source, form one interrupt request.

On the output side, the block drives the active-low request-to-send line. That line follows a control bit directly unless automatic enabling is on. With automatic enabling on, a clear of the control bit does not release the line at once. The release waits for the transmitter to drain, or in frame mode, when selected, for the closing flag to leave the data line. A second output either carries the inverse of a terminal-ready control bit or serves as an active-low transmit DMA request.

Top module: `modem_ctl`

## Requirements
- R1: `cts_o` and `dcd_o` are 1 when the corresponding pin is low, and follow a pin change after two rising clock edges.
- R2: With `auto_en_i` = 1, `tx_en_o` equals `cts_o` and `rx_en_o` equals `dcd_o`.
- R3: With `auto_en_i` = 0, `tx_en_o` and `rx_en_o` are both 1 whatever the pin levels.
- R4: Bit 0 of `chg_o` (clear-to-send) and bit 1 (carrier-detect) are set on the clock edge after the synchronized level changes in either direction. Each flag stays set until a 1 on the matching bit of `chg_clr_i` clears it at a clock edge. A new change at that same edge keeps the flag set.
- R5: `irq_o` is 1 exactly when some bit of `chg_o` is 1 while the same bit of `chg_en_i` is 1.
- R6: With `auto_en_i` = 0, `rts_no` is the inverse of `rts_bit_i`.
- R7: With `auto_en_i` = 1 and `rts_bit_i` = 1, `rts_no` is 0 in the same cycle.
- R8: With `auto_en_i` = 1, once `rts_bit_i` is cleared `rts_no` stays 0 until a clock edge that samples the release condition true. It goes to 1 after that edge. The release condition is `tx_empty_i` = 1, except in the R9 case.
- R9: When `frame_mode_i` = 1, `auto_rts_off_i` = 1 and `alt_mode_i` = 0, the release condition is `flag_done_i` = 1 and `tx_empty_i` has no effect on `rts_no`.
- R10: With `dtr_sel_i` = 0, `dtr_req_no` is the inverse of `dtr_bit_i`. With `dtr_sel_i` = 1, it is the inverse of `tx_dma_req_i`.
- R11: During reset all change flags are 0, `irq_o` is 0, both status outputs are 0, and the held request-to-send state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_en_i | input | 1 | Automatic enable mode |
| frame_mode_i | input | 1 | Frame (bit-oriented) mode selected |
| auto_rts_off_i | input | 1 | Release request-to-send on closing flag |
| alt_mode_i | input | 1 | Alternate mode; disables flag-based release |
| rts_bit_i | input | 1 | Request-to-send control bit |
| dtr_bit_i | input | 1 | Terminal-ready control bit |
| dtr_sel_i | input | 1 | 0: terminal-ready output, 1: DMA request output |
| tx_empty_i | input | 1 | Transmitter drained |
| flag_done_i | input | 1 | Closing flag has left the data line |
| tx_dma_req_i | input | 1 | Transmit DMA request, active high |
| cts_ni | input | 1 | Clear-to-send pin, active low, asynchronous |
| dcd_ni | input | 1 | Carrier-detect pin, active low, asynchronous |
| chg_clr_i | input | 2 | Write-one clear of change flags |
| chg_en_i | input | 2 | Per-source interrupt enable |
| cts_o | output | 1 | Synchronized clear-to-send, active high |
| dcd_o | output | 1 | Synchronized carrier-detect, active high |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| chg_o | output | 2 | Sticky change flags |
| irq_o | output | 1 | Interrupt request |
| rts_no | output | 1 | Request-to-send pin, active low |
| dtr_req_no | output | 1 | Terminal-ready / DMA request pin, active low |

## Verification
The hardest case to reach is the held request-to-send state. Automatic enabling must be on, the control bit must be set and then cleared, and the release event must stay absent for several cycles before it arrives. The frame-mode variant also needs `tx_empty_i` to pulse while the line is held, so the test shows that it is ignored there. The stimulus runs in phases that fix the mode bits and skew the probabilities: the control bit toggles rarely and the release events are rare. Held intervals of many cycles therefore occur again and again. A behavioural model is compared against all outputs on every cycle.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int unsigned N_SRC   = 2;
  localparam int unsigned SRC_CTS = 0;
  localparam int unsigned SRC_DCD = 1;

  typedef struct packed {
    logic frame_mode;
    logic auto_rts_off;
    logic alt_mode;
  } rts_cfg_t;
endpackage

// File: rtl/modem_pin_sync.sv
module modem_pin_sync #(
  parameter int unsigned N_PINS = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pins_ni,
  output logic [N_PINS-1:0] level_o,
  output logic [N_PINS-1:0] edge_o
);
  localparam int unsigned TOP = STAGES - 1;

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q   <= '1;
        prev_q <= 1'b1;
      end else begin
        sh_q   <= {sh_q[STAGES-2:0], pins_ni[g]};
        prev_q <= sh_q[TOP];
      end
    end

    assign level_o[g] = ~sh_q[TOP];
    assign edge_o[g]  = sh_q[TOP] ^ prev_q;
  end
endmodule

// File: rtl/modem_chg_flags.sv
module modem_chg_flags #(
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] edge_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [N_SRC-1:0] en_i,
  output logic [N_SRC-1:0] flag_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] flag_q;

  // set has priority over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= edge_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_i);
endmodule

// File: rtl/modem_rts_ctl.sv
module modem_rts_ctl
  import modem_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     auto_en_i,
  input  logic     rts_bit_i,
  input  rts_cfg_t cfg_i,
  input  logic     tx_empty_i,
  input  logic     flag_done_i,
  output logic     rts_no
);
  logic hold_q;
  logic flag_rel;
  logic release_ev;

  assign flag_rel   = cfg_i.frame_mode & cfg_i.auto_rts_off & ~cfg_i.alt_mode;
  assign release_ev = flag_rel ? flag_done_i : tx_empty_i;

  // hold tracks the bit directly when auto-enable is off, so enabling later starts clean
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= rts_bit_i | (auto_en_i & hold_q & ~release_ev);
  end

  assign rts_no = ~(rts_bit_i | (auto_en_i & hold_q));
endmodule

// File: rtl/modem_ctl.sv
module modem_ctl
  import modem_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_en_i,
  input  logic             frame_mode_i,
  input  logic             auto_rts_off_i,
  input  logic             alt_mode_i,
  input  logic             rts_bit_i,
  input  logic             dtr_bit_i,
  input  logic             dtr_sel_i,
  input  logic             tx_empty_i,
  input  logic             flag_done_i,
  input  logic             tx_dma_req_i,
  input  logic             cts_ni,
  input  logic             dcd_ni,
  input  logic [N_SRC-1:0] chg_clr_i,
  input  logic [N_SRC-1:0] chg_en_i,
  output logic             cts_o,
  output logic             dcd_o,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic [N_SRC-1:0] chg_o,
  output logic             irq_o,
  output logic             rts_no,
  output logic             dtr_req_no
);
  logic [N_SRC-1:0] pins_n;
  logic [N_SRC-1:0] level;
  logic [N_SRC-1:0] edges;
  rts_cfg_t         cfg;

  assign pins_n[SRC_CTS] = cts_ni;
  assign pins_n[SRC_DCD] = dcd_ni;

  modem_pin_sync #(.N_PINS(N_SRC), .STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pins_ni (pins_n),
    .level_o (level),
    .edge_o  (edges)
  );

  modem_chg_flags #(.N_SRC(N_SRC)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_i (edges),
    .clr_i  (chg_clr_i),
    .en_i   (chg_en_i),
    .flag_o (chg_o),
    .irq_o  (irq_o)
  );

  assign cfg.frame_mode   = frame_mode_i;
  assign cfg.auto_rts_off = auto_rts_off_i;
  assign cfg.alt_mode     = alt_mode_i;

  modem_rts_ctl u_rts (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .auto_en_i   (auto_en_i),
    .rts_bit_i   (rts_bit_i),
    .cfg_i       (cfg),
    .tx_empty_i  (tx_empty_i),
    .flag_done_i (flag_done_i),
    .rts_no      (rts_no)
  );

  assign cts_o      = level[SRC_CTS];
  assign dcd_o      = level[SRC_DCD];
  assign tx_en_o    = ~auto_en_i | level[SRC_CTS];
  assign rx_en_o    = ~auto_en_i | level[SRC_DCD];
  assign dtr_req_no = dtr_sel_i ? ~tx_dma_req_i : ~dtr_bit_i;
endmodule

// File: rtl/modem_ctl_chk.sv
module modem_ctl_chk
  import modem_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             auto_en_i,
  input logic             frame_mode_i,
  input logic             auto_rts_off_i,
  input logic             alt_mode_i,
  input logic             rts_bit_i,
  input logic             dtr_bit_i,
  input logic             dtr_sel_i,
  input logic             tx_empty_i,
  input logic             flag_done_i,
  input logic             tx_dma_req_i,
  input logic             cts_ni,
  input logic             dcd_ni,
  input logic [N_SRC-1:0] chg_clr_i,
  input logic [N_SRC-1:0] chg_en_i,
  input logic             cts_o,
  input logic             dcd_o,
  input logic             tx_en_o,
  input logic             rx_en_o,
  input logic [N_SRC-1:0] chg_o,
  input logic             irq_o,
  input logic             rts_no,
  input logic             dtr_req_no
);
  // R3
  enables_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |-> (tx_en_o && rx_en_o));

  // R2
  gated_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_en_i |-> (tx_en_o == cts_o && rx_en_o == dcd_o));

  // R4
  cts_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_o[SRC_CTS] && !chg_clr_i[SRC_CTS]) |=> chg_o[SRC_CTS]);

  // R4
  dcd_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_o[SRC_DCD] && !chg_clr_i[SRC_DCD]) |=> chg_o[SRC_DCD]);

  // R5
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (chg_o & chg_en_i) != '0);

  // R6
  rts_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |-> (rts_no == !rts_bit_i));

  // R7
  rts_assert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && rts_bit_i) |-> !rts_no);

  // R8
  rts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && !rts_no && !frame_mode_i && !tx_empty_i) |=> (!auto_en_i || !rts_no));

  // R9
  rts_flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && !rts_no && frame_mode_i && auto_rts_off_i && !alt_mode_i && !flag_done_i)
      |=> (!auto_en_i || !rts_no));

  // R10
  dma_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dtr_sel_i |-> (dtr_req_no == !tx_dma_req_i));
endmodule

bind modem_ctl modem_ctl_chk u_chk (.*);

// File: tb/modem_ctl_test.sv
module modem_ctl_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic auto_en, frame_mode, auto_rts_off, alt_mode, rts_bit, dtr_bit, dtr_sel;
  logic tx_empty, flag_done, tx_dma_req, cts_n, dcd_n;
  logic [1:0] chg_clr, chg_en;
  logic cts_s, dcd_s, tx_en, rx_en, irq, rts_n, dtr_req_n;
  logic [1:0] chg;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // behavioural model state
  int c1 = 1, c2 = 1, cp = 1, d1 = 1, d2 = 1, dp = 1;
  bit [1:0] m_chg = 0;
  bit m_hold = 0;

  always #2.5 clk = ~clk;

  modem_ctl uut (
    .clk_i(clk), .rst_ni(rst_ni), .auto_en_i(auto_en), .frame_mode_i(frame_mode),
    .auto_rts_off_i(auto_rts_off), .alt_mode_i(alt_mode), .rts_bit_i(rts_bit),
    .dtr_bit_i(dtr_bit), .dtr_sel_i(dtr_sel), .tx_empty_i(tx_empty),
    .flag_done_i(flag_done), .tx_dma_req_i(tx_dma_req), .cts_ni(cts_n), .dcd_ni(dcd_n),
    .chg_clr_i(chg_clr), .chg_en_i(chg_en), .cts_o(cts_s), .dcd_o(dcd_s),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .chg_o(chg), .irq_o(irq), .rts_no(rts_n),
    .dtr_req_no(dtr_req_n)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit flag_release();
    return frame_mode && auto_rts_off && !alt_mode;
  endfunction

  task automatic model_step();
    bit ec, ed, rel;
    ec = (c2 != cp);
    ed = (d2 != dp);
    rel = flag_release() ? flag_done : tx_empty;
    m_chg[0] = ec | (m_chg[0] & ~chg_clr[0]);
    m_chg[1] = ed | (m_chg[1] & ~chg_clr[1]);
    m_hold = rts_bit | (auto_en & m_hold & ~rel);
    cp = c2; c2 = c1; c1 = cts_n;
    dp = d2; d2 = d1; d1 = dcd_n;
  endtask

  task automatic check_all(input bit in_reset);
    int e_cts, e_dcd, e_rts;
    string rtag;
    vectors++;
    e_cts = (c2 == 0);
    e_dcd = (d2 == 0);
    cmp(in_reset ? "R11 cts_o" : "R1 cts_o", cts_s, e_cts);
    cmp(in_reset ? "R11 dcd_o" : "R1 dcd_o", dcd_s, e_dcd);
    cmp(auto_en ? "R2 tx_en_o" : "R3 tx_en_o", tx_en, !auto_en || e_cts);
    cmp(auto_en ? "R2 rx_en_o" : "R3 rx_en_o", rx_en, !auto_en || e_dcd);
    cmp(in_reset ? "R11 chg_o" : "R4 chg_o", chg, m_chg);
    cmp(in_reset ? "R11 irq_o" : "R5 irq_o", irq, (m_chg & chg_en) != 0);
    e_rts = !(rts_bit || (auto_en && m_hold));
    if (!auto_en) rtag = "R6 rts_no";
    else if (rts_bit) rtag = "R7 rts_no";
    else if (flag_release()) rtag = "R9 rts_no";
    else rtag = "R8 rts_no";
    cmp(rtag, rts_n, e_rts);
    cmp("R10 dtr_req_no", dtr_req_n, dtr_sel ? !tx_dma_req : !dtr_bit);
  endtask

  function automatic bit chance(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  task automatic drive(input int phase);
    case (phase)
      0: begin auto_en = 0; end
      1: begin auto_en = 1; frame_mode = 0; tx_empty = chance(8); flag_done = chance(50); end
      2: begin auto_en = 1; frame_mode = 1; auto_rts_off = 1; alt_mode = 0;
               flag_done = chance(8); tx_empty = chance(50); end
      3: begin auto_en = 1; frame_mode = 1; alt_mode = 1; auto_rts_off = chance(50);
               tx_empty = chance(10); flag_done = chance(50); end
      default: begin
        if (chance(5)) auto_en = ~auto_en;
        frame_mode = chance(50); auto_rts_off = chance(50); alt_mode = chance(30);
        tx_empty = chance(15); flag_done = chance(15);
      end
    endcase
    if (phase == 0) begin tx_empty = chance(50); flag_done = chance(50); end
    if (chance(12)) rts_bit = ~rts_bit;
    if (chance(8)) cts_n = ~cts_n;
    if (chance(8)) dcd_n = ~dcd_n;
    chg_clr = {chance(15), chance(15)};
    if (chance(10)) chg_en = 2'($urandom);
    if (chance(20)) dtr_sel = ~dtr_sel;
    dtr_bit = chance(50);
    tx_dma_req = chance(50);
  endtask

  initial begin
    auto_en = 0; frame_mode = 0; auto_rts_off = 0; alt_mode = 0; rts_bit = 0;
    dtr_bit = 0; dtr_sel = 0; tx_empty = 0; flag_done = 0; tx_dma_req = 0;
    cts_n = 1; dcd_n = 1; chg_clr = 0; chg_en = 2'b11;
    // R11: reset state, with pins toggling
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_all(1);
      cts_n = i[0]; dcd_n = ~i[0];
    end
    cts_n = 1; dcd_n = 1;
    @(negedge clk);
    rst_ni = 1'b1;
    for (int phase = 0; phase < 5; phase++) begin
      for (int cyc = 0; cyc < 600; cyc++) begin
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all(0);
        drive(phase);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule